// File: doc/BRIEF.md
# Latched Push-Pull PWM Generator

This block is a digital pulse-width modulator with two alternating drive outputs. It suits push-pull or single-ended switching converters. A free-running counter sets the switching period. A short blanking window at the head of each period does two jobs: it restarts the modulator, and it fixes the minimum dead time between the two drives. A duty command is compared against the counter. When the count reaches the command, a termination latch ends the pulse. The latch stays set until the next blanking window, so any one period carries at most one pulse.

A steering flip-flop sends successive periods to alternate outputs, so each drive can reach just under half duty. An external restart pulse lets several instances run in lockstep. A shutdown request ends the running pulse on the next clock edge. If the request is held, it keeps both drives off for as long as it is asserted.

Top module: `pushpull_pwm`

## Requirements
- R1: The counter runs from 0 to `period_len`-1 and then wraps to 0. `period_start` is high for exactly one cycle per period, in the first cycle of the blanking window, so consecutive strobes are `period_len` cycles apart.
- R2: While the count is below `blank_len`, both `drv_a` and `drv_b` are low.
- R3: In a period assigned to an output, that output is high from count `blank_len` up to, but not including, the count equal to `duty_cmd`. The pulse is therefore min(`duty_cmd`,`period_len`)-`blank_len` cycles long when that value is positive, and zero otherwise. A `duty_cmd` of 0 gives no pulse.
- R4: After a pulse has ended, no further pulse starts in the same period, even if `duty_cmd` is raised afterwards.
- R5: If `shut_req` is high in a cycle, both outputs are low in the next cycle. While it stays high, the outputs stay low. A one-cycle request affects only the current period.
- R6: The outputs take turns on successive periods. The first period after reset drives `drv_a`.
- R7: `drv_a` and `drv_b` are never high in the same cycle.
- R8: If `sync_in` is high in a cycle, the next cycle has count 0 and lies in the blanking window. When that restart interrupts a running period, `period_start` pulses and the steering moves to the other output.
- R9: While `rst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_len | input | CNT_W | Period length in cycles |
| blank_len | input | CNT_W | Blanking (dead-time) length in cycles |
| duty_cmd | input | CNT_W | Count at which the pulse terminates |
| sync_in | input | 1 | Restart the period on the next cycle |
| shut_req | input | 1 | Shutdown request, sampled each cycle |
| drv_a | output | 1 | First drive output, high = on |
| drv_b | output | 1 | Second drive output, high = on |
| period_start | output | 1 | One-cycle strobe at each blanking start |

## Verification
The checks on the counter range and on the blanking behaviour assume some limits on the inputs. `period_len` must be at least 2. `blank_len` must lie between 1 and `period_len`-1. Both may change only at count 0 or together with a restart. The stimulus applies every new period and blanking setting while the counter sits at zero and then issues a restart, and it only ever changes `duty_cmd` and `shut_req` in the middle of a period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    // Which drive the current period is steered to.
    typedef enum logic {
        PHASE_A = 1'b0,
        PHASE_B = 1'b1
    } phase_e;

    function automatic phase_e other_phase(input phase_e p);
        return (p == PHASE_A) ? PHASE_B : PHASE_A;
    endfunction
endpackage

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_len,
    input  logic [CNT_W-1:0] blank_len,
    input  logic             sync_in,
    output logic [CNT_W-1:0] cnt,
    output logic             blank,
    output logic             start
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             blank_prev;
    } ramp_t;

    ramp_t ramp_d, ramp_q;

    always_comb begin
        ramp_d = ramp_q;
        blank  = (ramp_q.cnt < blank_len);
        start  = blank && !ramp_q.blank_prev;
        if (sync_in) begin
            ramp_d.cnt = '0;
        end else if (ramp_q.cnt >= period_len - STEP) begin
            ramp_d.cnt = '0;
        end else begin
            ramp_d.cnt = ramp_q.cnt + STEP;
        end
        ramp_d.blank_prev = blank;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_q <= '0;
        end else begin
            ramp_q <= ramp_d;
        end
    end

    assign cnt = ramp_q.cnt;

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_q.cnt < period_len);

    // R8
    sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> (ramp_q.cnt == '0));
endmodule

// File: rtl/pwm_gate.sv
module pwm_gate
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty_cmd,
    input  logic             blank,
    input  logic             start,
    input  logic             shut_req,
    output logic             pwm_off,
    output phase_e           phase
);
    typedef struct packed {
        logic   latched;
        phase_e phase;
    } gate_t;

    gate_t gate_d, gate_q;
    logic  reached;

    always_comb begin
        gate_d  = gate_q;
        reached = (cnt >= duty_cmd);
        pwm_off = gate_q.latched || reached;
        // shutdown wins; blanking clears; otherwise the latch is sticky
        gate_d.latched = shut_req || (!blank && pwm_off);
        if (start) begin
            gate_d.phase = other_phase(gate_q.phase);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q.latched <= 1'b1;
            gate_q.phase   <= PHASE_B;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign phase = gate_q.phase;

    // R4
    term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && gate_q.latched) |=> gate_q.latched);

    // R6
    steer_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (gate_q.phase != $past(gate_q.phase)));
endmodule

// File: rtl/pwm_drive.sv
module pwm_drive
    import pwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   blank,
    input  logic   pwm_off,
    input  phase_e phase,
    output logic   drv_a,
    output logic   drv_b
);
    // An output is on only when blanking, termination and its steering are all low.
    always_comb begin
        drv_a = !(blank || pwm_off || (phase != PHASE_A));
        drv_b = !(blank || pwm_off || (phase != PHASE_B));
    end

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_a && drv_b));

    // R2
    blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (!drv_a && !drv_b));
endmodule

// File: rtl/pushpull_pwm.sv
module pushpull_pwm
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_len,
    input  logic [CNT_W-1:0] blank_len,
    input  logic [CNT_W-1:0] duty_cmd,
    input  logic             sync_in,
    input  logic             shut_req,
    output logic             drv_a,
    output logic             drv_b,
    output logic             period_start
);
    logic [CNT_W-1:0] cnt;
    logic             blank;
    logic             start;
    logic             pwm_off;
    phase_e           phase;

    pwm_ramp #(.CNT_W(CNT_W)) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_len (period_len),
        .blank_len  (blank_len),
        .sync_in    (sync_in),
        .cnt        (cnt),
        .blank      (blank),
        .start      (start)
    );

    pwm_gate #(.CNT_W(CNT_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .duty_cmd (duty_cmd),
        .blank    (blank),
        .start    (start),
        .shut_req (shut_req),
        .pwm_off  (pwm_off),
        .phase    (phase)
    );

    pwm_drive u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .blank   (blank),
        .pwm_off (pwm_off),
        .phase   (phase),
        .drv_a   (drv_a),
        .drv_b   (drv_b)
    );

    assign period_start = start;

    // R5
    shut_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shut_req |=> (!drv_a && !drv_b));
endmodule

// File: tb/pushpull_pwm_test.sv
module pushpull_pwm_test;
    localparam int CNT_W = 16;
    localparam int NVEC  = 7;
    // period, blanking, duty command, expected pulse cycles per driven period
    localparam int VEC [NVEC][4] = '{
        '{10, 2,  6, 4},
        '{10, 2,  0, 0},
        '{10, 2, 20, 8},
        '{10, 3,  3, 0},
        '{16, 4, 12, 8},
        '{ 8, 1,  8, 7},
        '{12, 2,  7, 5}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] period_len, blank_len, duty_cmd;
    logic             sync_in, shut_req;
    logic             drv_a, drv_b, period_start;

    int checks = 0;
    int fails  = 0;

    pushpull_pwm #(.CNT_W(CNT_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_len   (period_len),
        .blank_len    (blank_len),
        .duty_cmd     (duty_cmd),
        .sync_in      (sync_in),
        .shut_req     (shut_req),
        .drv_a        (drv_a),
        .drv_b        (drv_b),
        .period_start (period_start)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Restart, then let one full period pass so the count is 0 at a fresh strobe.
    task automatic align();
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        repeat (int'(period_len)) @(negedge clk);
    endtask

    // Sum of cycles with either output high over one period from count 0.
    task automatic count_period(output int on_cycles);
        on_cycles = 0;
        for (int i = 0; i < int'(period_len); i++) begin
            on_cycles += int'(drv_a) + int'(drv_b);
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int a_cnt, b_cnt, s_cnt, ovl, bviol, tot, exp_on, seen_a, gap;
        rst_n = 1'b0; sync_in = 1'b0; shut_req = 1'b0;
        period_len = 16'd10; blank_len = 16'd2; duty_cmd = 16'd6;
        repeat (3) @(negedge clk);
        // R9: drives low in reset
        chk("R9 drv_a in reset", int'(drv_a), 0);
        chk("R9 drv_b in reset", int'(drv_b), 0);
        rst_n = 1'b1;
        // R6: first period on drv_a, second on drv_b
        for (int p = 0; p < 2; p++) begin
            a_cnt = 0; b_cnt = 0;
            for (int i = 0; i < 10; i++) begin
                a_cnt += int'(drv_a); b_cnt += int'(drv_b);
                @(negedge clk);
            end
            chk($sformatf("R6 period%0d drv_a", p), a_cnt, (p == 0) ? 4 : 0);
            chk($sformatf("R6 period%0d drv_b", p), b_cnt, (p == 0) ? 0 : 4);
        end

        // Vector table: R1 R2 R3 R7 over four periods each
        for (int v = 0; v < NVEC; v++) begin
            period_len = 16'(VEC[v][0]);
            blank_len  = 16'(VEC[v][1]);
            duty_cmd   = 16'(VEC[v][2]);
            align();
            a_cnt = 0; b_cnt = 0; s_cnt = 0; ovl = 0; bviol = 0;
            for (int i = 0; i < 4 * VEC[v][0]; i++) begin
                a_cnt += int'(drv_a); b_cnt += int'(drv_b);
                s_cnt += int'(period_start);
                if (drv_a && drv_b) ovl++;
                if ((i % VEC[v][0]) < VEC[v][1] && (drv_a || drv_b)) bviol++;
                @(negedge clk);
            end
            exp_on = 2 * VEC[v][3];
            chk($sformatf("R3 vec%0d drv_a", v), a_cnt, exp_on);
            chk($sformatf("R3 vec%0d drv_b", v), b_cnt, exp_on);
            chk($sformatf("R1 vec%0d strobes", v), s_cnt, 4);
            chk($sformatf("R7 vec%0d overlap", v), ovl, 0);
            chk($sformatf("R2 vec%0d blank", v), bviol, 0);
        end

        // R4: raising the duty after termination gives no second pulse
        period_len = 16'd20; blank_len = 16'd2; duty_cmd = 16'd6;
        align();
        tot = 0;
        for (int i = 0; i < 20; i++) begin
            tot += int'(drv_a) + int'(drv_b);
            if (i == 8) duty_cmd = 16'd15;
            @(negedge clk);
        end
        chk("R4 no repulse", tot, 4);
        count_period(tot);
        chk("R4 next period wider", tot, 13);

        // R5: one-cycle shutdown ends the pulse, next period unaffected
        align();
        tot = 0;
        for (int i = 0; i < 20; i++) begin
            tot += int'(drv_a) + int'(drv_b);
            if (i == 5) shut_req = 1'b1;
            if (i == 6) shut_req = 1'b0;
            @(negedge clk);
        end
        chk("R5 short shutdown", tot, 4);
        count_period(tot);
        chk("R5 after short shutdown", tot, 13);

        // R5: held shutdown keeps both low, recovery after release
        shut_req = 1'b1;
        tot = 0;
        for (int i = 0; i < 40; i++) begin
            tot += int'(drv_a) + int'(drv_b);
            @(negedge clk);
        end
        chk("R5 held shutdown", tot, 0);
        shut_req = 1'b0;
        count_period(tot);
        chk("R5 recovery", tot, 13);

        // R8: mid-period restart
        duty_cmd = 16'd30;
        align();
        seen_a = 0;
        for (int i = 0; i <= 10; i++) begin
            if (i == 5) seen_a = int'(drv_a);
            if (i == 10) sync_in = 1'b1;
            @(negedge clk);
        end
        sync_in = 1'b0;
        chk("R8 strobe after sync", int'(period_start), 1);
        chk("R8 blank after sync", int'(drv_a) + int'(drv_b), 0);
        @(negedge clk);
        @(negedge clk);
        chk("R8 steer moved drv_a", int'(drv_a), 1 - seen_a);
        chk("R8 steer moved drv_b", int'(drv_b), seen_a);
        // R1: next strobe exactly one period later
        gap = 2;
        while (!period_start && gap < 100) begin
            @(negedge clk);
            gap++;
        end
        chk("R1 strobe spacing", gap, 20);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule